// File: doc/BRIEF.md
# MMU Fault Status Capture

This block sits beside a memory-management translation unit and records what went wrong when a translation fails. On a fault strobe it merges the access index and the fault word (type and table level) into a fault status register, sets a bit that marks the fault address as valid, and loads the full faulting virtual address into a fault address register. Both registers drive a read port that software samples.

A software read of the status register clears it on the following clock. If a second fault arrives while the status register still holds an unread value, the block treats this as an overflow. It collapses the old contents to a lone overflow bit and then merges the fields of the new fault on top.

Each fault may also raise a one-cycle exception request. The request's type bit tells an instruction fetch fault from a data access fault. The request is withheld when no-fault mode is on or traps are disabled. Trap vectoring happens elsewhere.

Top module: `mmu_fault_capture`

## Requirements
- R1: When `flt_strobe` is high at a clock edge, the next status value has these fields: `flt_aidx` in bits 7:5, `flt_word` bits 4:2 in bits 4:2, `flt_word` bits 9:8 in bits 9:8, and bit 1 set. All other bits are zero unless R2 applies.
- R2: If the status register is nonzero when a fault is captured and `stat_rd` is low in that cycle, bit 0 (overflow) is also set in the new value. Every other field comes only from the new fault.
- R3: On every captured fault, the fault address register takes the full value of `flt_addr`.
- R4: Bits of `flt_word` outside 9:8 and 4:2 have no effect on the status register.
- R5: When `stat_rd` is high and `flt_strobe` is low, the status register reads zero from the next cycle on.
- R6: When `stat_rd` and `flt_strobe` are high in the same cycle, the fault wins. The status register takes the new fault fields and the overflow bit stays clear.
- R7: With `flt_strobe` and `stat_rd` both low, the status and fault address registers hold their values.
- R8: One cycle after a captured fault with `nofault_mode` low and `traps_en` high, `exc_req` is high for exactly that one cycle. `exc_is_insn` equals bit 1 (fetch) of the access index. In the access index, bit 2 means write, bit 1 means fetch and bit 0 means supervisor.
- R9: A fault captured while `nofault_mode` is high or `traps_en` is low raises no exception request.
- R10: `exc_is_insn` is 0 in every cycle in which `exc_req` is 0.
- R11: After reset, the status register, the fault address register, `exc_req` and `exc_is_insn` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_strobe | input | 1 | A translation fault is reported this cycle |
| flt_word | input | 32 | Fault word: type in bits 4:2, level in bits 9:8 |
| flt_aidx | input | 3 | Access index {write, fetch, supervisor} |
| flt_addr | input | 32 | Faulting virtual address |
| nofault_mode | input | 1 | No-fault mode, suppresses exceptions |
| traps_en | input | 1 | Traps enabled |
| stat_rd | input | 1 | Software reads the status register this cycle |
| stat_q | output | 32 | Fault status register |
| far_q | output | 32 | Fault address register |
| exc_req | output | 1 | One-cycle exception request |
| exc_is_insn | output | 1 | Exception type: 1 instruction access, 0 data access |

## Verification
The hard case to reach from the ports is a fault that finds the status register still occupied. It has to be checked both with and without a read in the same cycle, because that read decides whether the overflow bit appears. The sweep varies how each fault relates to a read. It cycles through three cases: a read in a separate cycle beforehand, no read at all, and a read in the very cycle of the fault. These three cases cover every access index, fault type, level and trap-control combination, so occupied-register captures occur with every field pattern. The bench keeps its own arithmetic model of the register to predict each value.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int WORD_W   = 32;
  localparam int AIDX_W   = 3;
  localparam int OVF_BIT  = 0;
  localparam int FAV_BIT  = 1;
  localparam int TYPE_LSB = 2;
  localparam int TYPE_W   = 3;
  localparam int AIDX_LSB = 5;
  localparam int LVL_LSB  = 8;
  localparam int LVL_W    = 2;
  localparam int FETCH_BIT = 1;

  typedef enum logic {EXC_DATA = 1'b0, EXC_INSN = 1'b1} exc_kind_e;

  // Keep only the type and level fields of a fault word.
  function automatic logic [WORD_W-1:0] word_fields(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = 0; b < TYPE_W; b++) m[TYPE_LSB+b] = 1'b1;
    for (int b = 0; b < LVL_W; b++)  m[LVL_LSB+b]  = 1'b1;
    return w & m;
  endfunction

  // Build a full status value from a new fault.
  function automatic logic [WORD_W-1:0] compose_status(
      input logic              ovf,
      input logic [AIDX_W-1:0] aidx,
      input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] s;
    s = word_fields(w);
    s[AIDX_LSB +: AIDX_W] = aidx;
    s[FAV_BIT] = 1'b1;
    s[OVF_BIT] = ovf;
    return s;
  endfunction

  function automatic exc_kind_e kind_of(input logic [AIDX_W-1:0] aidx);
    return aidx[FETCH_BIT] ? EXC_INSN : EXC_DATA;
  endfunction
endpackage

// File: rtl/mfc_status_reg.sv
module mfc_status_reg
  import mfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              rd_clr,
  input  logic [AIDX_W-1:0] aidx,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] stat,
  output logic              ovf_event
);
  logic              occupied;
  logic [WORD_W-1:0] stat_nx;

  assign occupied  = |stat;
  assign ovf_event = capture && !rd_clr && occupied;

  always_comb begin
    stat_nx = stat;
    if (capture)     stat_nx = compose_status(ovf_event, aidx, word);
    else if (rd_clr) stat_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_nx;
  end

  AST_VALID_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> stat[FAV_BIT]); // R1
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !rd_clr && stat != '0) |=> stat[OVF_BIT]); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !capture) |=> stat == '0); // R5
  AST_SAME_CYCLE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && capture) |=> !stat[OVF_BIT]); // R6
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !capture) |=> $stable(stat)); // R7
endmodule

// File: rtl/mfc_addr_reg.sv
module mfc_addr_reg #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [VA_W-1:0] addr,
  output logic [VA_W-1:0] far
);
  always_ff @(posedge clk) begin
    if (!rst_n)       far <= '0;
    else if (capture) far <= addr;
  end

  AST_FAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> far == $past(addr)); // R3
  AST_FAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(far)); // R7
endmodule

// File: rtl/mfc_exc_sel.sv
module mfc_exc_sel
  import mfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [AIDX_W-1:0] aidx,
  input  logic              nofault_mode,
  input  logic              traps_en,
  output logic              req,
  output logic              is_insn
);
  logic      raise;
  exc_kind_e kind;

  assign raise = capture && traps_en && !nofault_mode;
  assign kind  = kind_of(aidx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req     <= 1'b0;
      is_insn <= 1'b0;
    end else begin
      req     <= raise;
      is_insn <= raise && (kind == EXC_INSN);
    end
  end

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(capture)); // R8
  AST_REQ_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && traps_en && !nofault_mode) |=> (req && is_insn == $past(aidx[FETCH_BIT]))); // R8
  AST_REQ_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && (nofault_mode || !traps_en)) |=> !req); // R9
  AST_TYPE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !is_insn); // R10
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mfc_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flt_strobe,
  input  logic [WORD_W-1:0]   flt_word,
  input  logic [AIDX_W-1:0]   flt_aidx,
  input  logic [VA_W-1:0]     flt_addr,
  input  logic                nofault_mode,
  input  logic                traps_en,
  input  logic                stat_rd,
  output logic [WORD_W-1:0]   stat_q,
  output logic [VA_W-1:0]     far_q,
  output logic                exc_req,
  output logic                exc_is_insn
);
  logic ovf_event;

  mfc_status_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (flt_strobe),
    .rd_clr    (stat_rd),
    .aidx      (flt_aidx),
    .word      (flt_word),
    .stat      (stat_q),
    .ovf_event (ovf_event)
  );

  mfc_addr_reg #(.VA_W(VA_W)) u_far (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (flt_strobe),
    .addr    (flt_addr),
    .far     (far_q)
  );

  mfc_exc_sel u_exc (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (flt_strobe),
    .aidx         (flt_aidx),
    .nofault_mode (nofault_mode),
    .traps_en     (traps_en),
    .req          (exc_req),
    .is_insn      (exc_is_insn)
  );

  AST_OVF_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_strobe && !ovf_event) |=> !stat_q[OVF_BIT]); // R2
  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (stat_q == '0 && far_q == '0 && !exc_req && !exc_is_insn)); // R11
endmodule

// File: tb/sim_mmu_fault_capture.sv
`timescale 1ns/1ps
module sim_mmu_fault_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_strobe = 1'b0;
  logic [31:0] flt_word = '0;
  logic [2:0]  flt_aidx = '0;
  logic [31:0] flt_addr = '0;
  logic        nofault_mode = 1'b0;
  logic        traps_en = 1'b0;
  logic        stat_rd = 1'b0;
  logic [31:0] stat_q;
  logic [31:0] far_q;
  logic        exc_req;
  logic        exc_is_insn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  longint m_stat = 0;
  longint m_far = 0;

  always #2.5 clk = ~clk;

  mmu_fault_capture u0 (.*);

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, sample at the following negedge.
  task automatic step(input bit s, input longint w, input int a, input longint ad,
                      input bit nf, input bit te, input bit rd, input string tag);
    longint typ, lvl, fields;
    bit     er, ei;
    flt_strobe = s; flt_word = w[31:0]; flt_aidx = a[2:0]; flt_addr = ad[31:0];
    nofault_mode = nf; traps_en = te; stat_rd = rd;
    typ = (w / 4) % 8;
    lvl = (w / 256) % 4;
    fields = a * 32 + typ * 4 + lvl * 256 + 2;
    er = 1'b0; ei = 1'b0;
    if (s) begin
      m_stat = fields + ((m_stat != 0 && !rd) ? 1 : 0);
      m_far = ad;
      er = !nf && te;
      ei = er && ((a / 2) % 2 == 1);
    end else if (rd) begin
      m_stat = 0;
    end
    @(posedge clk);
    @(negedge clk);
    flt_strobe = 1'b0; stat_rd = 1'b0;
    check({tag, " R1 R2 R4 R5 R6 R7 status"}, stat_q, m_stat);
    check({tag, " R3 R7 far"}, far_q, m_far);
    check({tag, " R8 R9 exc_req"}, exc_req, er);
    check({tag, " R8 R10 exc_is_insn"}, exc_is_insn, ei);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 stat", stat_q, 0);
    check("R11 far", far_q, 0);
    check("R11 req", exc_req, 0);
    check("R11 type", exc_is_insn, 0);

    // R7 idle hold with nothing captured
    step(0, 0, 0, 0, 0, 1, 0, "idle");

    // Sweep: access index x type x level x nofault x traps, three read relations.
    for (int i = 0; i < 1024; i++) begin
      int     a, typ, lvl, mode;
      bit     nf, te;
      longint junk, w, ad;
      a = i % 8; typ = (i / 8) % 8; lvl = (i / 64) % 4;
      nf = ((i / 256) % 2) == 1; te = ((i / 512) % 2) == 0;
      mode = i % 3;
      // R4: garbage in every non-field bit
      junk = (longint'(i) * 64'h9E3779B1) % 64'h1_0000_0000;
      junk = junk - (junk % 1024) + (junk % 4) + ((junk / 32) % 8) * 32;
      w = junk + typ * 4 + lvl * 256;
      ad = ((longint'(i) * 64'h01000193) + 64'hC0DE0000) % 64'h1_0000_0000;
      if (mode == 0) step(0, 0, 0, 0, 0, 1, 1, "pre-read R5");
      step(1, w, a, ad, nf, te, (mode == 2), "fault");
      if (i % 7 == 0) step(0, 0, 0, 0, 0, 1, 0, "hold");
    end

    // Back-to-back faults: overflow and two consecutive pulses
    step(1, 32'h0000_0304, 3, 32'hFFFF_FFFF, 0, 1, 0, "b2b first");
    step(1, 32'h0000_0118, 6, 32'h0000_0001, 0, 1, 0, "b2b second R2");
    step(0, 0, 0, 0, 0, 1, 1, "final read R5");
    step(0, 0, 0, 0, 0, 1, 0, "final idle R7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule